// File: doc/BRIEF.md
# Serial-Programmed Switch-Select Controller

This block is the digital control path for an analog multiplexer built from two banks of sixteen switches. A host drives a three-wire frame: an active-low frame strobe, a serial clock and serial data. While the strobe is low, the block collects one 8-bit command word, most significant bit first, on falling serial-clock edges. It applies the word on its own as soon as the eighth edge has arrived. All three pins are oversampled by a faster system clock through two-flop synchronizers, so the system clock must run at least four times the serial clock rate.

The decoded command drives two one-hot switch-enable vectors. In dual-bank mode (`WIDE = 0`) each bank has its own keep bit, so one command can move bank A, bank B, both, or neither. In wide mode (`WIDE = 1`) the two vectors form a single 32-way selector, with channels 1 to 16 on `sw_a_o` and channels 17 to 32 on `sw_b_o`. A global off bit opens every switch. When a closed channel is replaced by another, the affected bank is held fully open for one system clock first. A one-clock `upd_o` pulse marks the first cycle in which the final setting is on the outputs.

Top module: `swsel_ctrl`

## Requirements
- R1: After reset every switch is open and `upd_o` is low. Serial-clock activity while the strobe is high changes nothing.
- R2: With the strobe low, bits are taken on falling serial-clock edges, MSB first. After the eighth edge the word is applied and `upd_o` pulses without any rise of the strobe.
- R3: Once eight edges have been taken, further falling edges in the same low-strobe period are ignored. There is no second update and no change of outputs until the strobe has gone high and low again.
- R4: If the strobe rises before the eighth edge, the partial word is discarded with no update. The next frame counts its edges from zero.
- R5: Dual-bank mode: bits 3..0 hold address n, and every bank whose keep bit is 0 closes channel n+1, which is bit n of its output vector. Bit 4 has no effect.
- R6: Dual-bank mode: bit 6 is the keep bit of bank A and bit 5 is the keep bit of bank B. A bank whose keep bit is 1 retains its previous state, so with both bits set and bit 7 at 0 nothing changes.
- R7: Bit 7 set opens every switch in both banks, whatever the keep bits hold.
- R8: Wide mode: bits 4..0 pick channel k+1. For k < 16 this is bit k of `sw_a_o`, otherwise bit k-16 of `sw_b_o`. Bit 6 set retains the previous state and bit 5 has no effect.
- R9: When a selection moves from one closed channel to a different one, the moving bank reads all-open for exactly one system clock before the new channel closes. The other bank holds its old value during that cycle. In wide mode both vectors count as one bank.
- R10: Each accepted word gives exactly one one-clock `upd_o` pulse, in the first cycle that shows the final setting. Outside the open gap of R9, outputs change only in that cycle.
- R11: At most one switch is closed per bank in dual-bank mode, and at most one over all 32 in wide mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n_i | input | 1 | Active-low frame strobe (asynchronous) |
| sclk_i | input | 1 | Serial clock, data taken on falling edges (asynchronous) |
| sdi_i | input | 1 | Serial data, MSB first (asynchronous) |
| sw_a_o | output | 16 | Bank A switch enables; channels 1..16 in wide mode |
| sw_b_o | output | 16 | Bank B switch enables; channels 17..32 in wide mode |
| upd_o | output | 1 | One-clock pulse when a new setting is in place |

## Verification
A wrong edge count or a shift register that is not cleared shows at the ports within the same frame. Either an update arrives early or late against the model, or the decoded channel lands on the wrong bit, and this is seen a few system clocks after the eighth falling edge. A wrong keep or off decode, or a lost previous state, only shows on the next word that relies on retention. For this reason every command value is sent twice, in two different orders, so each keep case follows many different prior states. A missing or extra open-gap cycle is visible in the single cycle just before `upd_o`.

// File: rtl/swsel_pkg.sv
`timescale 1ns/1ps
package swsel_pkg;
  localparam int WORD_W     = 8;
  localparam int OFF_BIT    = 7;
  localparam int KEEP_A_BIT = 6;
  localparam int KEEP_B_BIT = 5;

  typedef struct packed {
    logic frame_n;
    logic sclk;
    logic sdi;
  } ser_pins_t;

  localparam int PINS_W = $bits(ser_pins_t);
  localparam ser_pins_t PINS_IDLE = '{frame_n: 1'b1, sclk: 1'b1, sdi: 1'b0};
endpackage

// File: rtl/swsel_sync.sv
`timescale 1ns/1ps
module swsel_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/swsel_shifter.sv
`timescale 1ns/1ps
module swsel_shifter
  import swsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W);

  logic              sclk_q;
  logic              fall;
  logic [CNT_W-1:0]  cnt;
  logic              done;
  logic [WORD_W-2:0] shreg;

  assign fall = sclk_q & ~sclk_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q     <= 1'b1;
      cnt        <= '0;
      done       <= 1'b0;
      shreg      <= '0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      sclk_q     <= sclk_s;
      word_vld_o <= 1'b0;
      if (frame_n_s) begin
        cnt  <= '0;
        done <= 1'b0;
      end else if (fall && !done) begin
        shreg <= {shreg[WORD_W-3:0], sdi_s};
        if (cnt == CNT_W'(WORD_W-1)) begin
          cnt        <= '0;
          done       <= 1'b1;
          word_vld_o <= 1'b1;
          word_o     <= {shreg, sdi_s};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/swsel_decode.sv
`timescale 1ns/1ps
module swsel_decode
  import swsel_pkg::*;
#(
  parameter int BANK_CH = 16,
  parameter bit WIDE = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               word_vld_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic [BANK_CH-1:0] sw_a_o,
  output logic [BANK_CH-1:0] sw_b_o,
  output logic               upd_o
);
  localparam int ALL_CH = 2 * BANK_CH;
  localparam int NA_W   = $clog2(BANK_CH);
  localparam int WA_W   = $clog2(ALL_CH);

  logic [BANK_CH-1:0] tgt_a, tgt_b, hold_a, hold_b;
  logic               gap_a, gap_b, pend;

  if (WIDE) begin : g_wide
    logic [ALL_CH-1:0] cur, hot, tgt;
    logic unused_bits;
    assign unused_bits = word_i[KEEP_B_BIT] ^ (^word_i[KEEP_B_BIT-1:WA_W]);
    always_comb begin
      cur = {sw_b_o, sw_a_o};
      hot = '0;
      hot[word_i[WA_W-1:0]] = 1'b1;
      if (word_i[OFF_BIT])          tgt = '0;
      else if (word_i[KEEP_A_BIT])  tgt = cur;
      else                          tgt = hot;
      {tgt_b, tgt_a} = tgt;
      gap_a = (cur != '0) && (tgt != '0) && (tgt != cur);
      gap_b = gap_a;
    end
  end else begin : g_dual
    logic [BANK_CH-1:0] hot;
    logic unused_bits;
    assign unused_bits = ^word_i[KEEP_B_BIT-1:NA_W];
    always_comb begin
      hot = '0;
      hot[word_i[NA_W-1:0]] = 1'b1;
      tgt_a = sw_a_o;
      tgt_b = sw_b_o;
      if (word_i[OFF_BIT]) begin
        tgt_a = '0;
        tgt_b = '0;
      end else begin
        if (!word_i[KEEP_A_BIT]) tgt_a = hot;
        if (!word_i[KEEP_B_BIT]) tgt_b = hot;
      end
      gap_a = (sw_a_o != '0) && (tgt_a != '0) && (tgt_a != sw_a_o);
      gap_b = (sw_b_o != '0) && (tgt_b != '0) && (tgt_b != sw_b_o);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_a_o <= '0;
      sw_b_o <= '0;
      hold_a <= '0;
      hold_b <= '0;
      pend   <= 1'b0;
      upd_o  <= 1'b0;
    end else begin
      upd_o <= 1'b0;
      if (word_vld_i) begin
        if (gap_a || gap_b) begin
          sw_a_o <= gap_a ? '0 : sw_a_o;
          sw_b_o <= gap_b ? '0 : sw_b_o;
          hold_a <= tgt_a;
          hold_b <= tgt_b;
          pend   <= 1'b1;
        end else begin
          sw_a_o <= tgt_a;
          sw_b_o <= tgt_b;
          upd_o  <= 1'b1;
          pend   <= 1'b0;
        end
      end else if (pend) begin
        sw_a_o <= hold_a;
        sw_b_o <= hold_b;
        upd_o  <= 1'b1;
        pend   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/swsel_ctrl.sv
`timescale 1ns/1ps
module swsel_ctrl
  import swsel_pkg::*;
#(
  parameter int BANK_CH = 16,
  parameter bit WIDE = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_n_i,
  input  logic               sclk_i,
  input  logic               sdi_i,
  output logic [BANK_CH-1:0] sw_a_o,
  output logic [BANK_CH-1:0] sw_b_o,
  output logic               upd_o
);
  ser_pins_t         pins_raw, pins_s;
  logic              word_vld;
  logic [WORD_W-1:0] word;

  always_comb begin
    pins_raw.frame_n = frame_n_i;
    pins_raw.sclk    = sclk_i;
    pins_raw.sdi     = sdi_i;
  end

  swsel_sync #(
    .W(PINS_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk(clk), .rst(rst), .d_i(pins_raw), .q_o(pins_s)
  );

  swsel_shifter u_shift (
    .clk(clk), .rst(rst),
    .frame_n_s(pins_s.frame_n), .sclk_s(pins_s.sclk), .sdi_s(pins_s.sdi),
    .word_vld_o(word_vld), .word_o(word)
  );

  swsel_decode #(.BANK_CH(BANK_CH), .WIDE(WIDE)) u_dec (
    .clk(clk), .rst(rst), .word_vld_i(word_vld), .word_i(word),
    .sw_a_o(sw_a_o), .sw_b_o(sw_b_o), .upd_o(upd_o)
  );
endmodule

// File: rtl/swsel_ctrl_chk.sv
`timescale 1ns/1ps
module swsel_ctrl_chk #(
  parameter int BANK_CH = 16,
  parameter bit WIDE = 1'b0
) (
  input logic               clk,
  input logic               rst,
  input logic [BANK_CH-1:0] sw_a_o,
  input logic [BANK_CH-1:0] sw_b_o,
  input logic               upd_o
);
  p_reset_open_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sw_a_o == '0 && sw_b_o == '0 && !upd_o));

  p_upd_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    upd_o |=> !upd_o);

  p_quiet_a_r10: assert property (@(posedge clk) disable iff (rst)
    (sw_a_o != $past(sw_a_o)) |-> (upd_o || sw_a_o == '0));

  p_quiet_b_r10: assert property (@(posedge clk) disable iff (rst)
    (sw_b_o != $past(sw_b_o)) |-> (upd_o || sw_b_o == '0));

  if (WIDE) begin : g_wide
    p_onehot_r11: assert property (@(posedge clk) disable iff (rst)
      $onehot0({sw_b_o, sw_a_o}));
    p_bbm_r9: assert property (@(posedge clk) disable iff (rst)
      (($past({sw_b_o, sw_a_o}) != '0) && ({sw_b_o, sw_a_o} != '0))
        |-> ({sw_b_o, sw_a_o} == $past({sw_b_o, sw_a_o})));
  end else begin : g_dual
    p_onehot_r11: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sw_a_o) && $onehot0(sw_b_o));
    p_bbm_a_r9: assert property (@(posedge clk) disable iff (rst)
      (($past(sw_a_o) != '0) && (sw_a_o != '0)) |-> (sw_a_o == $past(sw_a_o)));
    p_bbm_b_r9: assert property (@(posedge clk) disable iff (rst)
      (($past(sw_b_o) != '0) && (sw_b_o != '0)) |-> (sw_b_o == $past(sw_b_o)));
  end
endmodule

bind swsel_ctrl swsel_ctrl_chk #(.BANK_CH(BANK_CH), .WIDE(WIDE)) u_chk (
  .clk(clk), .rst(rst), .sw_a_o(sw_a_o), .sw_b_o(sw_b_o), .upd_o(upd_o)
);

// File: tb/test_swsel_ctrl.sv
`timescale 1ns/1ps
module test_swsel_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic [15:0] d_a, d_b, w_a, w_b;
  logic d_upd, w_upd;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  swsel_ctrl #(.WIDE(1'b0)) i_swsel_ctrl (
    .clk(clk), .rst(rst), .frame_n_i(frame_n), .sclk_i(sclk), .sdi_i(sdi),
    .sw_a_o(d_a), .sw_b_o(d_b), .upd_o(d_upd));

  swsel_ctrl #(.WIDE(1'b1)) i_swsel_ctrl_wide (
    .clk(clk), .rst(rst), .frame_n_i(frame_n), .sclk_i(sclk), .sdi_i(sdi),
    .sw_a_o(w_a), .sw_b_o(w_b), .upd_o(w_upd));

  // upd monitors: count pulses, remember the values one cycle before the pulse
  int d_cnt = 0, w_cnt = 0;
  logic [15:0] d_la = 0, d_lb = 0, d_pa = 0, d_pb = 0;
  logic [31:0] w_l = 0, w_p = 0;
  always @(negedge clk) begin
    if (!rst && d_upd) begin d_cnt++; d_pa = d_la; d_pb = d_lb; end
    if (!rst && w_upd) begin w_cnt++; w_p = w_l; end
    d_la = d_a; d_lb = d_b; w_l = {w_b, w_a};
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [7:0] w, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdi = w[i]; #20; sclk = 1'b0; #20; sclk = 1'b1;
    end
  endtask

  logic [15:0] m_a = 0, m_b = 0;
  logic [31:0] m_w = 0;

  task automatic do_word(input logic [7:0] w);
    logic [15:0] na, nb; logic [31:0] nw; bit ga, gb, gw;
    na = m_a; nb = m_b; nw = m_w;
    if (w[7]) begin na = 0; nb = 0; nw = 0; end
    else begin
      if (!w[6]) na = 16'(1) << w[3:0];
      if (!w[5]) nb = 16'(1) << w[3:0];
      if (!w[6]) nw = 32'(1) << w[4:0];
    end
    ga = (m_a != 0) && (na != 0) && (na != m_a);
    gb = (m_b != 0) && (nb != 0) && (nb != m_b);
    gw = (m_w != 0) && (nw != 0) && (nw != m_w);
    d_cnt = 0; w_cnt = 0;
    frame_n = 1'b0; #20;
    shift_bits(w, 8);
    #100;
    // strobe still low here
    chk(d_cnt == 1, "R2 dual update after 8 edges", d_cnt, 1);
    chk(w_cnt == 1, "R2 wide update after 8 edges", w_cnt, 1);
    chk(d_a == na, "R5/R6/R7 dual bank A", d_a, na);
    chk(d_b == nb, "R5/R6/R7 dual bank B", d_b, nb);
    chk({w_b, w_a} == nw, "R8/R7 wide select", {w_b, w_a}, nw);
    chk(d_pa == (ga ? 16'h0 : m_a), "R9 dual A before update", d_pa, ga ? 16'h0 : m_a);
    chk(d_pb == (gb ? 16'h0 : m_b), "R9 dual B before update", d_pb, gb ? 16'h0 : m_b);
    chk(w_p == (gw ? 32'h0 : m_w), "R9 wide before update", w_p, gw ? 32'h0 : m_w);
    frame_n = 1'b1; #40;
    chk(d_cnt == 1 && w_cnt == 1, "R10 single pulse per word", d_cnt + w_cnt, 2);
    m_a = na; m_b = nb; m_w = nw;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    #50;
    chk(d_a == 0 && d_b == 0 && !d_upd, "R1 dual reset open", {d_b, d_a}, 0);
    chk(w_a == 0 && w_b == 0 && !w_upd, "R1 wide reset open", {w_b, w_a}, 0);
    // clocks with strobe high
    d_cnt = 0; w_cnt = 0;
    shift_bits(8'h03, 8); #100;
    chk(d_cnt == 0 && w_cnt == 0 && d_a == 0 && w_a == 0, "R1 clocks with strobe high ignored",
        d_cnt + w_cnt, 0);

    // R4: partial frame discarded, next frame starts from zero
    do_word(8'h21);  // dual A=ch2, B kept open; wide ch2
    d_cnt = 0; w_cnt = 0;
    frame_n = 1'b0; #20; shift_bits(8'h03, 5); frame_n = 1'b1; #100;
    chk(d_cnt == 0 && w_cnt == 0, "R4 partial word no update", d_cnt + w_cnt, 0);
    chk(d_a == m_a && d_b == m_b && {w_b, w_a} == m_w, "R4 outputs kept", {d_b, d_a}, {m_b, m_a});
    do_word(8'h05);

    // R3: extra edges in the same frame ignored
    do_word(8'h02);
    d_cnt = 0; w_cnt = 0;
    frame_n = 1'b0; #20; shift_bits(8'h0C, 8); shift_bits(8'hFF, 6); #100;
    chk(d_cnt == 1 && w_cnt == 1, "R3 one update only", d_cnt + w_cnt, 2);
    chk(d_a == 16'h1000 && d_b == 16'h1000, "R3 dual holds first word", {d_b, d_a}, 32'h10001000);
    chk({w_b, w_a} == 32'h1000, "R3 wide holds first word", {w_b, w_a}, 32'h1000);
    frame_n = 1'b1; #40;
    m_a = 16'h1000; m_b = 16'h1000; m_w = 32'h1000;

    // exhaustive sweeps, two orders
    for (int i = 0; i < 256; i++) do_word(8'(i));
    for (int i = 0; i < 256; i++) do_word(8'((i * 37 + 11) & 255));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule